// File: doc/BRIEF.md
# Dual/Quad Pipeline Register Bank

This block holds four byte-wide registers, organised as two pairs (first pair: A1 then A2; second pair: B1 then B2), all updated on the rising clock edge from one shared byte input. A 2-bit operation code chosen on each clock either keeps all four registers, shifts the data down one chain through all four, or loads the input into the head register of one pair. Used this way, the bank serves either as two separate 2-deep delay lines or as one 4-deep delay line.

A 2-bit output select routes any one of the four registers to the byte output. An active-low output enable drives that output; when it is high the output floats. A build-time parameter selects how a head load treats the pair: in push mode the old head value moves into the second register of that pair, and in overwrite mode only the head changes.

Top module: `mlpr_top`

## Requirements
- R1: While the active-low reset `rst_n` is low, all four registers are cleared to zero, and every select value then reads 0x00.
- R2: Operation code 3 leaves all four registers unchanged across the clock edge.
- R3: Operation code 0 shifts in one edge: input to A1, A1 to A2, A2 to B1, B1 to B2.
- R4: Operation code 2 writes the input into A1 and leaves B1 and B2 unchanged.
- R5: Operation code 1 writes the input into B1 and leaves A1 and A2 unchanged.
- R6: With `PUSH_ON_LOAD` = 1, code 2 also copies the old A1 into A2, and code 1 copies the old B1 into B2, on the same edge.
- R7: With `PUSH_ON_LOAD` = 0, codes 1 and 2 leave A2 and B2 unchanged.
- R8: With `oe_n` low, the output shows A1 for select 0, A2 for 1, B1 for 2 and B2 for 3. The select path is combinational.
- R9: With `oe_n` high, all output bits are high-impedance, whatever the select.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; the release is synchronised |
| din | input | 8 | Shared data input |
| op | input | 2 | Operation code: 0 shift, 1 load B1, 2 load A1, 3 hold |
| sel | input | 2 | Output register select: 0 A1, 1 A2, 2 B1, 3 B2 |
| oe_n | input | 1 | Active-low output enable |
| y | output | 8 | Selected register, or high-impedance |

## Verification
A wrong register value is stored state, so it appears at `y` for the select that addresses it as soon as the edge that wrote it has passed. It then moves down the chain with each later shift. The bench therefore reads all four select values in every cycle, and any wrong move or wrong load shows up within half a clock of the faulty edge, before another operation can hide it. Both loading modes are built side by side and driven with the same stimulus, so a push that leaks into overwrite mode, or the reverse, shows as a mismatch on the second-level registers.

// File: rtl/mlpr_pkg.sv
package mlpr_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT  = 2'd0,
    OP_LOAD_B = 2'd1,
    OP_LOAD_A = 2'd2,
    OP_HOLD   = 2'd3
  } mlpr_op_e;

  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned IDX_A1 = 0;
  localparam int unsigned IDX_A2 = 1;
  localparam int unsigned IDX_B1 = 2;
  localparam int unsigned IDX_B2 = 3;
endpackage

// File: rtl/mlpr_rst_sync.sv
module mlpr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/mlpr_bank.sv
module mlpr_bank
  import mlpr_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          PUSH_ON_LOAD = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [WIDTH-1:0]               din,
  input  logic [1:0]                     op,
  output logic [NUM_REGS-1:0][WIDTH-1:0] regs
);
  logic [NUM_REGS-1:0][WIDTH-1:0] regs_q, regs_d;
  logic [NUM_REGS-1:0]            en;
  mlpr_op_e                       op_e;

  assign op_e = mlpr_op_e'(op);

  // Next-state values and per-register clock enables
  always_comb begin
    regs_d = regs_q;
    en     = '0;
    unique case (op_e)
      OP_SHIFT: begin
        regs_d[IDX_A1] = din;
        regs_d[IDX_A2] = regs_q[IDX_A1];
        regs_d[IDX_B1] = regs_q[IDX_A2];
        regs_d[IDX_B2] = regs_q[IDX_B1];
        en             = '1;
      end
      OP_LOAD_A: begin
        regs_d[IDX_A1] = din;
        en[IDX_A1]     = 1'b1;
        if (PUSH_ON_LOAD) begin
          regs_d[IDX_A2] = regs_q[IDX_A1];
          en[IDX_A2]     = 1'b1;
        end
      end
      OP_LOAD_B: begin
        regs_d[IDX_B1] = din;
        en[IDX_B1]     = 1'b1;
        if (PUSH_ON_LOAD) begin
          regs_d[IDX_B2] = regs_q[IDX_B1];
          en[IDX_B2]     = 1'b1;
        end
      end
      default: en = '0;
    endcase
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[g] <= '0;
      else if (en[g]) regs_q[g] <= regs_d[g];
    end
  end

  assign regs = regs_q;

  // R2: hold keeps everything
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd3) |=> $stable(regs_q));

  // R3: chain shift
  a_r3_shift_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd0) |=> (regs_q[0] == $past(din)) && (regs_q[1] == $past(regs_q[0]))
                  && (regs_q[2] == $past(regs_q[1])) && (regs_q[3] == $past(regs_q[2])));

  // R4: load A1 keeps the second pair
  a_r4_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd2) |=> (regs_q[0] == $past(din)) && $stable(regs_q[2]) && $stable(regs_q[3]));

  // R5: load B1 keeps the first pair
  a_r5_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd1) |=> (regs_q[2] == $past(din)) && $stable(regs_q[0]) && $stable(regs_q[1]));

  if (PUSH_ON_LOAD) begin : g_chk_push
    // R6: head value pushed to second level
    a_r6_push_a: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'd2) |=> (regs_q[1] == $past(regs_q[0])));
    a_r6_push_b: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'd1) |=> (regs_q[3] == $past(regs_q[2])));
  end else begin : g_chk_ovr
    // R7: second level untouched on loads
    a_r7_keep_second: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 2'd1 || op == 2'd2) |=> $stable(regs_q[1]) && $stable(regs_q[3]));
  end
endmodule

// File: rtl/mlpr_outsel.sv
module mlpr_outsel
  import mlpr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [NUM_REGS-1:0][WIDTH-1:0] regs,
  input  logic [1:0]                     sel,
  input  logic                           oe_n,
  output logic [WIDTH-1:0]               y
);
  logic [WIDTH-1:0] picked;

  always_comb begin
    unique case (sel)
      2'd0:    picked = regs[IDX_A1];
      2'd1:    picked = regs[IDX_A2];
      2'd2:    picked = regs[IDX_B1];
      default: picked = regs[IDX_B2];
    endcase
  end

  assign y = oe_n ? {WIDTH{1'bz}} : picked;
endmodule

// File: rtl/mlpr_top.sv
module mlpr_top
  import mlpr_pkg::*;
#(
  parameter int unsigned WIDTH        = 8,
  parameter bit          PUSH_ON_LOAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       op,
  input  logic [1:0]       sel,
  input  logic             oe_n,
  output logic [WIDTH-1:0] y
);
  logic                           rst_n_sync;
  logic [NUM_REGS-1:0][WIDTH-1:0] regs;

  mlpr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_sync)
  );

  mlpr_bank #(.WIDTH(WIDTH), .PUSH_ON_LOAD(PUSH_ON_LOAD)) u_bank (
    .clk  (clk),
    .rst_n(rst_n_sync),
    .din  (din),
    .op   (op),
    .regs (regs)
  );

  mlpr_outsel #(.WIDTH(WIDTH)) u_outsel (
    .regs(regs),
    .sel (sel),
    .oe_n(oe_n),
    .y   (y)
  );

  // R1: registers read zero while reset is held
  a_r1_reset_clear: assert property (@(posedge clk)
    (!rst_n_sync) |=> (regs == '0) || rst_n_sync);
endmodule

// File: tb/mlpr_top_bench.sv
`timescale 1ns/100ps
module mlpr_top_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] din;
  logic [1:0] op;
  logic [1:0] sel;
  logic       oe_n;
  wire  [7:0] y_push;
  wire  [7:0] y_ovr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] mp[4];
  logic [7:0] mo[4];

  always #2.5 clk = ~clk;

  mlpr_top #(.WIDTH(8), .PUSH_ON_LOAD(1'b1)) u_mlpr_top (
    .clk(clk), .rst_n(rst_n), .din(din), .op(op), .sel(sel), .oe_n(oe_n), .y(y_push));

  mlpr_top #(.WIDTH(8), .PUSH_ON_LOAD(1'b0)) u_mlpr_top_ovr (
    .clk(clk), .rst_n(rst_n), .din(din), .op(op), .sel(sel), .oe_n(oe_n), .y(y_ovr));

  function automatic string tag_of(input logic [1:0] o, input bit push);
    case (o)
      2'd0:    return "R3";
      2'd1:    return push ? "R5/R6" : "R5/R7";
      2'd2:    return push ? "R4/R6" : "R4/R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Read all four registers of both builds, then the disabled output (R8, R9)
  task automatic verify_all(input string tp, input string to);
    for (int s = 0; s < 4; s++) begin
      sel  = 2'(s);
      oe_n = 1'b0;
      #0.2;
      check(y_push, mp[s], {tp, " R8 push"});
      check(y_ovr,  mo[s], {to, " R8 ovr"});
    end
    oe_n = 1'b1;
    #0.2;
    check(y_push, 8'hzz, "R9 push");
    check(y_ovr,  8'hzz, "R9 ovr");
  endtask

  task automatic model_step(inout logic [7:0] m[4], input bit push,
                            input logic [7:0] d, input logic [1:0] o);
    case (o)
      2'd0: begin m[3] = m[2]; m[2] = m[1]; m[1] = m[0]; m[0] = d; end
      2'd2: begin if (push) m[1] = m[0]; m[0] = d; end
      2'd1: begin if (push) m[3] = m[2]; m[2] = d; end
      default: ;
    endcase
  endtask

  // Inputs are set at the falling edge, the models advance at the rising edge,
  // and the outputs are read back after the following falling edge.
  task automatic cycle(input logic [7:0] d, input logic [1:0] o);
    din = d;
    op  = o;
    @(posedge clk);
    model_step(mp, 1'b1, d, o);
    model_step(mo, 1'b0, d, o);
    @(negedge clk);
    verify_all(tag_of(o, 1'b1), tag_of(o, 1'b0));
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    din   = 8'h00;
    op    = 2'd3;
    sel   = 2'd0;
    oe_n  = 1'b0;
    for (int i = 0; i < 4; i++) begin mp[i] = 8'h00; mo[i] = 8'h00; end
    repeat (3) @(negedge clk);
    verify_all("R1", "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    verify_all("R1", "R1");

    // R3: fill the whole chain as a 4-deep line
    cycle(8'h11, 2'd0);
    cycle(8'h22, 2'd0);
    cycle(8'h33, 2'd0);
    cycle(8'h44, 2'd0);
    // R2: hold
    cycle(8'hFF, 2'd3);
    cycle(8'hEE, 2'd3);
    // R4, R6, R7: head loads of the first pair
    cycle(8'h5A, 2'd2);
    cycle(8'hA5, 2'd2);
    // R5, R6, R7: head loads of the second pair
    cycle(8'hC3, 2'd1);
    cycle(8'h3C, 2'd1);
    // mixed pattern
    cycle(8'h01, 2'd0);
    cycle(8'h02, 2'd1);
    cycle(8'h03, 2'd2);
    cycle(8'h04, 2'd3);
    cycle(8'h05, 2'd0);

    for (int n = 0; n < 300; n++)
      cycle(8'($urandom), 2'($urandom));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule